// File: doc/BRIEF.md
# Quad-Channel Serial Register Interface

This block is the digital front end of a four-channel converter. A host drives a four-wire serial port made up of an active-low select, a serial clock, serial data in and serial data out. The block decodes the frames it receives and keeps four 8-bit channel registers whose values drive the converter inputs in parallel. A frame has four parts in this order: a single 1 that marks the start, a 2-bit command, a 2-bit channel number and an eight-clock data phase. The command decides whether the data phase loads a register, shifts a register out, or is ignored.

The storage that keeps values across power cycles sits in a separate controller. This block reaches it through two one-cycle request pulses. A store request goes out when a write follows an arming command. A fetch request goes out on a recall, and the controller answers it with a data-valid strobe. While the controller reports busy, the serial port is deaf. The serial pins are sampled by the block's system clock, and the edges of the serial clock are detected internally, so every action lands a fixed number of system cycles after the serial edge that causes it.

Top module: `quad_serial_regs`

## Requirements
- R1: While reset is asserted and after it is released, all four channel values read zero, the output enable is low and neither request pulse is active.
- R2: With select low, serial zeros sampled before the first 1 are ignored. The first sampled 1 is the start bit, and the next two bits form the command, most significant bit first.
- R3: Command 01 (write) loads the eight data bits, MSB first, into the addressed channel. The channel number is the two bits after the command, MSB first, and channel c occupies bits [8c+7:8c] of `chan_value`. The load takes effect one system clock after the eighth data rising edge is seen. Other channels are not touched.
- R4: Command 10 (read) shifts the addressed channel out on `sdo`, MSB first. Each bit changes one system clock after a serial falling edge: D7 follows the falling edge after the last address bit, and D0 follows the falling edge after the seventh data bit. No channel value changes.
- R5: `sdo_en` is high only during the data phase of a read. It stays low during headers, during every other command and while select is high. It drops at the falling edge after the last read bit, or one clock after select rises.
- R6: Command 11 (recall) raises `nv_fetch_req` for one clock, with the channel on `nv_fetch_chan`, right after the address. When `nv_fetch_valid` comes back, `nv_fetch_data` loads that channel. Select may rise any time after the address.
- R7: Command 00 (arm) sets an arming flag, and its data bits are ignored. The next completed write then raises `nv_store_req` for one clock, with its channel and data, and clears the flag. A read or recall header clears the flag without issuing a request.
- R8: If select rises before the eighth data bit, the frame is dropped: no channel changes and no request is issued.
- R9: While `nv_busy` is high, every frame is ignored and `sdo_en` stays low.
- R10: After the eighth data bit of a frame, the bit counter returns to start-bit hunting. With select still low, further zeros are ignored, and a new 1 starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Drive enable for sdo; low means high-impedance |
| nv_busy | input | 1 | Nonvolatile controller busy |
| nv_store_req | output | 1 | One-cycle request to store a value |
| nv_store_chan | output | 2 | Channel of the store request |
| nv_store_data | output | 8 | Value to store |
| nv_fetch_req | output | 1 | One-cycle request to fetch a stored value |
| nv_fetch_chan | output | 2 | Channel of the fetch request |
| nv_fetch_valid | input | 1 | Fetched value is present |
| nv_fetch_data | input | 8 | Fetched value |
| chan_value | output | 32 | Four channel values, channel c at [8c+7:8c] |

## Verification
A rising serial edge is acted on at the next system clock edge. The registered event that results changes a channel value one more clock later. A falling serial edge changes `sdo` and `sdo_en` within one system clock. The bench holds each serial clock phase for three system clocks. It samples `sdo` and `sdo_en` two clocks into each low phase, so the bit launched by the preceding falling edge is always settled. Channel values, request counts and the recall result are read only after the frame has closed and a few idle clocks have passed, well beyond the two-clock write path and the fetch round trip.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

    localparam int unsigned QSR_CH = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CMD_W  = 2;
    localparam int unsigned ADDR_W = $clog2(QSR_CH);
    localparam int unsigned CNT_W  = $clog2(DATA_W);

    typedef enum logic [CMD_W-1:0] {
        CMD_NVEN   = 2'b00,
        CMD_WRITE  = 2'b01,
        CMD_READ   = 2'b10,
        CMD_RECALL = 2'b11
    } qsr_cmd_e;

    typedef enum logic [1:0] {
        PH_HUNT,
        PH_CMD,
        PH_ADDR,
        PH_DATA
    } qsr_phase_e;

    // header decoded: command and channel known
    typedef struct packed {
        logic            valid;
        qsr_cmd_e        cmd;
        logic [ADDR_W-1:0] chan;
    } qsr_hdr_t;

    // full frame received: data phase complete
    typedef struct packed {
        logic              valid;
        qsr_cmd_e          cmd;
        logic [ADDR_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } qsr_frame_t;

    function automatic logic is_last(input logic [CNT_W-1:0] cnt, input int unsigned len);
        return cnt == CNT_W'(len - 1);
    endfunction

endpackage

// File: rtl/qsr_frame_rx.sv
module qsr_frame_rx
    import qsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       sck,
    input  logic       sdi,
    input  logic       hold,
    output logic       sck_fall,
    output logic       data_phase,
    output qsr_hdr_t   hdr_evt,
    output qsr_frame_t done_evt
);

    logic              sck_q;
    logic              sck_rise;
    qsr_phase_e        ph;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [CMD_W:0]    cmd_nx;
    logic [ADDR_W:0]   addr_nx;
    logic [DATA_W:0]   data_nx;

    assign sck_rise   = sck & ~sck_q;
    assign sck_fall   = ~sck & sck_q;
    assign data_phase = (ph == PH_DATA);
    assign cmd_nx     = {cmd_q, sdi};
    assign addr_nx    = {addr_q, sdi};
    assign data_nx    = {data_q, sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            ph       <= PH_HUNT;
            cnt      <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            hdr_evt  <= '0;
            done_evt <= '0;
        end else begin
            sck_q          <= sck;
            hdr_evt.valid  <= 1'b0;
            done_evt.valid <= 1'b0;
            if (sel_n || hold) begin
                ph  <= PH_HUNT;
                cnt <= '0;
            end else if (sck_rise) begin
                case (ph)
                    PH_HUNT: begin
                        if (sdi) begin
                            ph  <= PH_CMD;
                            cnt <= '0;
                        end
                    end
                    PH_CMD: begin
                        cmd_q <= cmd_nx[CMD_W-1:0];
                        if (is_last(cnt, CMD_W)) begin
                            ph  <= PH_ADDR;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= addr_nx[ADDR_W-1:0];
                        if (is_last(cnt, ADDR_W)) begin
                            ph           <= PH_DATA;
                            cnt          <= '0;
                            hdr_evt.valid <= 1'b1;
                            hdr_evt.cmd   <= qsr_cmd_e'(cmd_q);
                            hdr_evt.chan  <= addr_nx[ADDR_W-1:0];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        data_q <= data_nx[DATA_W-1:0];
                        if (is_last(cnt, DATA_W)) begin
                            ph             <= PH_HUNT;
                            cnt            <= '0;
                            done_evt.valid <= 1'b1;
                            done_evt.cmd   <= qsr_cmd_e'(cmd_q);
                            done_evt.chan  <= addr_q;
                            done_evt.data  <= data_nx[DATA_W-1:0];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/qsr_dout_ser.sv
module qsr_dout_ser
    import qsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              hold,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              sck_fall,
    input  logic              data_phase,
    output logic              dout,
    output logic              dout_en
);

    logic [DATA_W-1:0] sh;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            armed   <= 1'b0;
            dout    <= 1'b0;
            dout_en <= 1'b0;
        end else if (sel_n || hold) begin
            armed   <= 1'b0;
            dout_en <= 1'b0;
        end else if (load) begin
            sh    <= load_val;
            armed <= 1'b1;
        end else if (sck_fall) begin
            if (armed && data_phase) begin
                dout    <= sh[DATA_W-1];
                sh      <= {sh[DATA_W-2:0], 1'b0};
                dout_en <= 1'b1;
            end else begin
                armed   <= 1'b0;
                dout_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qsr_reg_bank.sv
module qsr_reg_bank
    import qsr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  qsr_hdr_t                      hdr_evt,
    input  qsr_frame_t                    done_evt,
    input  logic                          fetch_valid,
    input  logic [DATA_W-1:0]             fetch_data,
    output logic [QSR_CH-1:0][DATA_W-1:0] vals,
    output logic                          store_req,
    output logic [ADDR_W-1:0]             store_chan,
    output logic [DATA_W-1:0]             store_data,
    output logic                          fetch_req,
    output logic [ADDR_W-1:0]             fetch_chan
);

    logic arm_q;
    logic wr_done;

    assign wr_done = done_evt.valid && (done_evt.cmd == CMD_WRITE);

    for (genvar c = 0; c < QSR_CH; c++) begin : g_ch
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_done && done_evt.chan == ADDR_W'(c)) begin
                q <= done_evt.data;
            end else if (fetch_valid && fetch_chan == ADDR_W'(c)) begin
                q <= fetch_data;
            end
        end
        assign vals[c] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q      <= 1'b0;
            store_req  <= 1'b0;
            store_chan <= '0;
            store_data <= '0;
            fetch_req  <= 1'b0;
            fetch_chan <= '0;
        end else begin
            store_req <= 1'b0;
            fetch_req <= 1'b0;
            if (hdr_evt.valid) begin
                case (hdr_evt.cmd)
                    CMD_NVEN:  arm_q <= 1'b1;
                    CMD_WRITE: arm_q <= arm_q;
                    CMD_RECALL: begin
                        arm_q      <= 1'b0;
                        fetch_req  <= 1'b1;
                        fetch_chan <= hdr_evt.chan;
                    end
                    default:   arm_q <= 1'b0;
                endcase
            end
            if (wr_done && arm_q) begin
                store_req  <= 1'b1;
                store_chan <= done_evt.chan;
                store_data <= done_evt.data;
                arm_q      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/quad_serial_regs.sv
module quad_serial_regs
    import qsr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel_n,
    input  logic                     sck,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_en,
    input  logic                     nv_busy,
    output logic                     nv_store_req,
    output logic [ADDR_W-1:0]        nv_store_chan,
    output logic [DATA_W-1:0]        nv_store_data,
    output logic                     nv_fetch_req,
    output logic [ADDR_W-1:0]        nv_fetch_chan,
    input  logic                     nv_fetch_valid,
    input  logic [DATA_W-1:0]        nv_fetch_data,
    output logic [QSR_CH*DATA_W-1:0] chan_value
);

    logic                          sck_fall;
    logic                          data_phase;
    qsr_hdr_t                      hdr_evt;
    qsr_frame_t                    done_evt;
    logic [QSR_CH-1:0][DATA_W-1:0] vals;
    logic                          rd_load;

    assign rd_load    = hdr_evt.valid && (hdr_evt.cmd == CMD_READ);
    assign chan_value = vals;

    qsr_frame_rx rx_i (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (sel_n),
        .sck        (sck),
        .sdi        (sdi),
        .hold       (nv_busy),
        .sck_fall   (sck_fall),
        .data_phase (data_phase),
        .hdr_evt    (hdr_evt),
        .done_evt   (done_evt)
    );

    qsr_dout_ser ser_i (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (sel_n),
        .hold       (nv_busy),
        .load       (rd_load),
        .load_val   (vals[hdr_evt.chan]),
        .sck_fall   (sck_fall),
        .data_phase (data_phase),
        .dout       (sdo),
        .dout_en    (sdo_en)
    );

    qsr_reg_bank bank_i (
        .clk         (clk),
        .rst         (rst),
        .hdr_evt     (hdr_evt),
        .done_evt    (done_evt),
        .fetch_valid (nv_fetch_valid),
        .fetch_data  (nv_fetch_data),
        .vals        (vals),
        .store_req   (nv_store_req),
        .store_chan  (nv_store_chan),
        .store_data  (nv_store_data),
        .fetch_req   (nv_fetch_req),
        .fetch_chan  (nv_fetch_chan)
    );

endmodule

// File: rtl/qsr_checker.sv
module qsr_checker
    import qsr_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     sel_n,
    input logic                     sdo_en,
    input logic                     nv_busy,
    input logic                     nv_store_req,
    input logic                     nv_fetch_req,
    input logic                     nv_fetch_valid,
    input logic [QSR_CH*DATA_W-1:0] chan_value
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (chan_value == '0 && !sdo_en && !nv_store_req && !nv_fetch_req));

    // R5
    a_r5_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        $past(sel_n) |-> !sdo_en);

    // R6
    a_r6_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
        nv_fetch_req |=> !nv_fetch_req);

    // R7
    a_r7_store_pulse: assert property (@(posedge clk) disable iff (rst)
        nv_store_req |=> !nv_store_req);

    // R8
    a_r8_no_change_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_n) && $past(sel_n, 2) && !$past(nv_fetch_valid)) |-> $stable(chan_value));

    // R9
    a_r9_busy_silent: assert property (@(posedge clk) disable iff (rst)
        $past(nv_busy) |-> !sdo_en);

endmodule

bind quad_serial_regs qsr_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .sel_n          (sel_n),
    .sdo_en         (sdo_en),
    .nv_busy        (nv_busy),
    .nv_store_req   (nv_store_req),
    .nv_fetch_req   (nv_fetch_req),
    .nv_fetch_valid (nv_fetch_valid),
    .chan_value     (chan_value)
);

// File: tb/quad_serial_regs_tb_top.sv
`timescale 1ns/1ps
module quad_serial_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        nv_busy = 1'b0;
    logic        nv_fetch_valid = 1'b0;
    logic [7:0]  nv_fetch_data = 8'h00;
    logic        sdo, sdo_en;
    logic        nv_store_req, nv_fetch_req;
    logic [1:0]  nv_store_chan, nv_fetch_chan;
    logic [7:0]  nv_store_data;
    logic [31:0] chan_value;

    int errors = 0;
    int checks = 0;
    int store_cnt = 0;
    int fetch_cnt = 0;
    logic [1:0] st_ch = 2'd0;
    logic [7:0] st_d = 8'h00;
    logic [1:0] fe_ch = 2'd0;
    logic [7:0] mdl [4];
    logic [7:0] nv_mem [4];
    logic smp_dout = 1'b0;
    logic smp_en = 1'b0;
    logic en_or = 1'b0;

    always #4 clk = ~clk;

    quad_serial_regs dut_i (
        .clk            (clk),
        .rst            (rst),
        .sel_n          (sel_n),
        .sck            (sck),
        .sdi            (sdi),
        .sdo            (sdo),
        .sdo_en         (sdo_en),
        .nv_busy        (nv_busy),
        .nv_store_req   (nv_store_req),
        .nv_store_chan  (nv_store_chan),
        .nv_store_data  (nv_store_data),
        .nv_fetch_req   (nv_fetch_req),
        .nv_fetch_chan  (nv_fetch_chan),
        .nv_fetch_valid (nv_fetch_valid),
        .nv_fetch_data  (nv_fetch_data),
        .chan_value     (chan_value)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        return {mdl[3], mdl[2], mdl[1], mdl[0]};
    endfunction

    // store monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (nv_store_req) begin
                store_cnt++;
                st_ch = nv_store_chan;
                st_d  = nv_store_data;
            end
        end
    end

    // nonvolatile controller model: answers fetches two cycles later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (nv_fetch_req) begin
                fetch_cnt++;
                fe_ch = nv_fetch_chan;
                repeat (2) @(negedge clk);
                nv_fetch_data  = nv_mem[fe_ch];
                nv_fetch_valid = 1'b1;
                @(negedge clk);
                nv_fetch_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic bit_out(input logic b);
        @(negedge clk);
        sck = 1'b0;
        sdi = b;
        repeat (2) @(negedge clk);
        smp_dout = sdo;
        smp_en   = sdo_en;
        en_or    = en_or | sdo_en;
        @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic begin_frame();
        @(negedge clk);
        sel_n = 1'b0;
        en_or = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk);
        sck = 1'b0;
        repeat (2) @(negedge clk);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic hdr(input logic [1:0] cmd, input logic [1:0] ch);
        bit_out(1'b1);
        bit_out(cmd[1]);
        bit_out(cmd[0]);
        bit_out(ch[1]);
        bit_out(ch[0]);
    endtask

    task automatic data_out(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic write_frame(input logic [1:0] ch, input logic [7:0] v);
        begin_frame();
        hdr(2'b01, ch);
        data_out(v);
        end_frame();
    endtask

    task automatic read_frame(input logic [1:0] ch, output logic [7:0] v,
                              output logic all_en, output logic hdr_en);
        begin_frame();
        hdr(2'b10, ch);
        hdr_en = en_or;
        all_en = 1'b1;
        v = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            bit_out(1'b0);
            v[i]   = smp_dout;
            all_en = all_en & smp_en;
        end
        end_frame();
    endtask

    initial begin
        logic [7:0] rv;
        logic       ae, he;
        for (int i = 0; i < 4; i++) begin
            mdl[i]    = 8'h00;
            nv_mem[i] = 8'h00;
        end
        nv_mem[3] = 8'h9E;
        nv_mem[0] = 8'h42;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(chan_value == 32'h0, "R1 chan_value after reset", chan_value, 0);
        chk(sdo_en == 1'b0, "R1 sdo_en after reset", sdo_en, 0);
        chk(store_cnt == 0 && fetch_cnt == 0, "R1 no requests", store_cnt + fetch_cnt, 0);

        // R3/R4/R5 sweep over all values, channels rotating
        for (int v = 0; v < 256; v++) begin
            logic [1:0] ch;
            ch = 2'(v % 4);
            write_frame(ch, 8'(v));
            mdl[ch] = 8'(v);
            chk(chan_value == model_word(), "R3 write sweep", chan_value, model_word());
            chk(en_or == 1'b0, "R5 enable low during write", en_or, 0);
            read_frame(ch, rv, ae, he);
            chk(rv == 8'(v), "R4 read value MSB first", rv, v);
            chk(ae == 1'b1, "R4 enable during read data", ae, 1);
            chk(he == 1'b0, "R5 enable low during read header", he, 0);
            chk(sdo_en == 1'b0, "R5 enable low after frame", sdo_en, 0);
            chk(chan_value == model_word(), "R4 read leaves values", chan_value, model_word());
        end

        // R2 leading zeros before start bit
        begin_frame();
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        hdr(2'b01, 2'd1);
        data_out(8'h3C);
        end_frame();
        mdl[1] = 8'h3C;
        chk(chan_value == model_word(), "R2 leading zeros ignored", chan_value, model_word());

        // R10 two frames inside one select
        begin_frame();
        hdr(2'b01, 2'd0);
        data_out(8'h5A);
        bit_out(1'b0); bit_out(1'b0);
        hdr(2'b01, 2'd2);
        data_out(8'hC3);
        end_frame();
        mdl[0] = 8'h5A;
        mdl[2] = 8'hC3;
        chk(chan_value == model_word(), "R10 back-to-back frames", chan_value, model_word());

        // R8 abort mid-write
        begin_frame();
        hdr(2'b01, 2'd3);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        end_frame();
        begin_frame();
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        end_frame();
        chk(chan_value == model_word(), "R8 aborted write no change", chan_value, model_word());
        chk(store_cnt == 0, "R8 no store on abort", store_cnt, 0);

        // R9 busy ignores frames
        nv_busy = 1'b1;
        write_frame(2'd0, 8'hFF);
        chk(chan_value == model_word(), "R9 write ignored when busy", chan_value, model_word());
        read_frame(2'd0, rv, ae, he);
        chk(en_or == 1'b0, "R9 sdo_en low when busy", en_or, 0);
        nv_busy = 1'b0;
        repeat (2) @(negedge clk);

        // R7 arm then write issues store
        begin_frame();
        hdr(2'b00, 2'd1);
        data_out(8'h00);
        end_frame();
        write_frame(2'd2, 8'hA5);
        mdl[2] = 8'hA5;
        repeat (3) @(negedge clk);
        chk(store_cnt == 1, "R7 store after arm and write", store_cnt, 1);
        chk(st_ch == 2'd2 && st_d == 8'hA5, "R7 store chan/data", {st_ch, st_d}, {2'd2, 8'hA5});
        chk(chan_value == model_word(), "R7 write also loads channel", chan_value, model_word());
        write_frame(2'd2, 8'h0F);
        mdl[2] = 8'h0F;
        repeat (3) @(negedge clk);
        chk(store_cnt == 1, "R7 arm cleared after store", store_cnt, 1);
        begin_frame();
        hdr(2'b00, 2'd0);
        end_frame();
        read_frame(2'd1, rv, ae, he);
        write_frame(2'd1, 8'h77);
        mdl[1] = 8'h77;
        repeat (3) @(negedge clk);
        chk(store_cnt == 1, "R7 read clears arm", store_cnt, 1);

        // R6 recall with select rising right after address
        begin_frame();
        hdr(2'b11, 2'd3);
        end_frame();
        repeat (8) @(negedge clk);
        mdl[3] = 8'h9E;
        chk(fetch_cnt == 1 && fe_ch == 2'd3, "R6 fetch request chan", {fetch_cnt[7:0], 6'd0, fe_ch}, {8'd1, 8'd3});
        chk(chan_value == model_word(), "R6 recall loads channel", chan_value, model_word());
        begin_frame();
        hdr(2'b11, 2'd0);
        data_out(8'hFF);
        end_frame();
        repeat (8) @(negedge clk);
        mdl[0] = 8'h42;
        chk(chan_value == model_word(), "R6 recall data ignored", chan_value, model_word());
        chk(store_cnt == 1, "R6 recall issues no store", store_cnt, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule